// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block takes over the memory bus of an 8-bit accumulator-style processor core whenever the core has to enter a reset, non-maskable interrupt or maskable interrupt handler. The core pulses `start` at each instruction boundary and presents its current program counter, stack pointer and status byte. The sequencer chooses which request to serve, if any. It then performs the entry bus cycles: two throw-away reads at the program counter, three stack cycles, and a two-byte vector fetch. At the end it returns the new program counter, stack pointer and status byte together with a one-cycle `done` pulse. If no request can be served, `done` comes back one cycle after `start` and the returned values equal the inputs.

The parameter `CMOS_VARIANT` selects between two behaviours. The later variant clears the decimal flag on every entry. The older variant keeps the decimal flag. It also honours two postponement hints from the core, which put off an interrupt by one instruction.

The controller is a state machine with the states IDLE, PEEK0, PEEK1, STK0, STK1, STK2, VLO and VHI. The transitions are: IDLE to PEEK0 when an entry is taken at a boundary, IDLE to IDLE otherwise, each state to the next one in the listed order, and VHI back to IDLE. A separate arbiter holds the pending reset and NMI latches and the postponement memory. A bus driver forms the address, write data and write enable for each state.

Top module: `irq_entry_seq`

## Requirements
- R1: At a boundary (`start` high while idle) a pending reset wins over a pending NMI, and an NMI wins over IRQ. IRQ is served only when status bit 2 (interrupt disable) of `flags_in` is 0.
- R2: The vector is read low byte first and then high byte. The addresses are 0xFFFA/0xFFFB for NMI, 0xFFFC/0xFFFD for reset and 0xFFFE/0xFFFF for IRQ. `pc_out` becomes {high, low}.
- R3: An NMI or IRQ entry reads twice at `pc_in`. It then writes PC[15:8], PC[7:0] and the status byte, in that order, to address 0x0100 | SP. SP decrements by one (modulo 256) after each of the three writes.
- R4: The pushed status byte equals `flags_in` with bit 5 forced to 1 and bit 4 forced to 0.
- R5: A reset entry reads twice at `pc_in` and then reads three times at 0x0100 | SP, with SP decrementing after each read. `bus_we` stays 0 for the whole entry.
- R6: After an entry, `flags_out` is the captured status with bit 2 set. The CMOS variant also clears bit 3 (decimal); the NMOS variant keeps it. All other bits pass through.
- R7: A one-cycle pulse on `reset_req` or `nmi_req` stays pending until its own entry begins and is cleared at that point. `irq_level` is a level and is never latched.
- R8: NMOS only, with no reset pending. `delay_all` at a boundary postpones a pending NMI or IRQ. `delay_irq` postpones only when no NMI is pending. A postponement never happens at two boundaries in a row. The CMOS variant ignores both hints.
- R9: An entry drives its seven bus accesses in the seven cycles after the `start` edge and pulses `done` for one cycle in the eighth. With nothing to serve (including a postponement), `done` pulses in the cycle after `start` and the outputs equal `pc_in`, `sp_in` and `flags_in`.
- R10: `pc_out`, `sp_out` and `flags_out` change only together with a `done` pulse. `start` during an entry is ignored.
- R11: `bus_we` is 0 while the sequencer is idle and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction-boundary strobe from the core |
| reset_req | input | 1 | Reset request pulse |
| nmi_req | input | 1 | Non-maskable interrupt request pulse |
| irq_level | input | 1 | Maskable interrupt request level |
| delay_all | input | 1 | Postpone-any hint (after a taken three-cycle branch) |
| delay_irq | input | 1 | Postpone-IRQ hint (after an interrupt-enable or status pull) |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 8 | Current stack pointer |
| flags_in | input | 8 | Current status byte |
| bus_addr | output | 16 | Memory address |
| bus_wdata | output | 8 | Memory write data |
| bus_we | output | 1 | Memory write enable |
| bus_rdata | input | 8 | Memory read data, valid in the access cycle |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | New program counter |
| sp_out | output | 8 | New stack pointer |
| flags_out | output | 8 | New status byte |

## Verification
The bench builds two copies side by side from the same stimulus: one with `CMOS_VARIANT` = 0 and one with `CMOS_VARIANT` = 1. The NMOS copy brings the postponement paths within reach: single postponement, NMI overriding the IRQ-only hint, and reset bypassing both hints. The CMOS copy serves the same requests without delay and clears the decimal flag, so the divergence between the two copies is itself checked. A behavioural model for each copy predicts every bus cycle, the `done` pulse and the held outputs on every clock.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int SP_W   = 8;

    localparam logic [ADDR_W-1:0] STACK_PAGE = 16'h0100;
    localparam logic [ADDR_W-1:0] VEC_NMI    = 16'hFFFA;
    localparam logic [ADDR_W-1:0] VEC_RST    = 16'hFFFC;
    localparam logic [ADDR_W-1:0] VEC_IRQ    = 16'hFFFE;

    localparam int FLG_I = 2;
    localparam int FLG_D = 3;
    localparam int FLG_B = 4;
    localparam int FLG_U = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PEEK0,
        ST_PEEK1,
        ST_STK0,
        ST_STK1,
        ST_STK2,
        ST_VLO,
        ST_VHI
    } seq_state_t;

    typedef enum logic [1:0] {
        EK_NONE,
        EK_RESET,
        EK_NMI,
        EK_IRQ
    } entry_kind_t;

    function automatic logic [ADDR_W-1:0] vector_base(entry_kind_t k);
        case (k)
            EK_NMI:   return VEC_NMI;
            EK_RESET: return VEC_RST;
            default:  return VEC_IRQ;
        endcase
    endfunction

endpackage

// File: rtl/irq_entry_arb.sv
module irq_entry_arb
    import irq_entry_pkg::*;
#(
    parameter bit CMOS_VARIANT = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        boundary,
    input  logic        reset_req,
    input  logic        nmi_req,
    input  logic        irq_level,
    input  logic        irq_masked,
    input  logic        delay_all,
    input  logic        delay_irq,
    output entry_kind_t kind_sel
);

    logic rst_pend;
    logic nmi_pend;
    logic rst_eff;
    logic nmi_eff;
    logic active;
    logic postpone;

    assign rst_eff = rst_pend | reset_req;
    assign nmi_eff = nmi_pend | nmi_req;
    assign active  = nmi_eff | irq_level;

    generate
        if (CMOS_VARIANT) begin : g_cmos
            assign postpone = 1'b0;
        end else begin : g_nmos
            logic delay_used;

            assign postpone = !rst_eff && !delay_used && active &&
                              (delay_all || (delay_irq && !nmi_eff));

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    delay_used <= 1'b0;
                end else if (boundary && !rst_eff) begin
                    delay_used <= postpone;
                end
            end

            // R8: a postponement is never granted at two boundaries in a row
            a_r8_once: assert property (@(posedge clk) disable iff (!rst_n)
                delay_used && boundary |-> !postpone);
        end
    endgenerate

    always_comb begin
        kind_sel = EK_NONE;
        if (boundary) begin
            if (rst_eff)
                kind_sel = EK_RESET;
            else if (postpone)
                kind_sel = EK_NONE;
            else if (nmi_eff)
                kind_sel = EK_NMI;
            else if (irq_level && !irq_masked)
                kind_sel = EK_IRQ;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_pend <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            rst_pend <= rst_eff && (kind_sel != EK_RESET);
            nmi_pend <= nmi_eff && (kind_sel != EK_NMI);
        end
    end

    // R7: request pulses outside a boundary are remembered
    a_r7_nmi_held: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req && !boundary |=> nmi_pend);
    a_r7_rst_held: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req && !boundary |=> rst_pend);

endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_entry_pkg::*;
#(
    parameter bit CMOS_VARIANT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  entry_kind_t       kind_sel,
    input  logic [DATA_W-1:0] rdata,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [SP_W-1:0]   sp_in,
    input  logic [DATA_W-1:0] flags_in,
    output seq_state_t        state,
    output entry_kind_t       kind_q,
    output logic [ADDR_W-1:0] pc_w,
    output logic [SP_W-1:0]   sp_w,
    output logic [DATA_W-1:0] flg_w,
    output logic              idle,
    output logic              done,
    output logic [ADDR_W-1:0] pc_out,
    output logic [SP_W-1:0]   sp_out,
    output logic [DATA_W-1:0] flags_out
);

    seq_state_t        state_nx;
    logic [DATA_W-1:0] vec_lo;
    logic [DATA_W-1:0] flg_new;

    assign idle = (state == ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (kind_sel != EK_NONE) state_nx = ST_PEEK0;
            ST_PEEK0: state_nx = ST_PEEK1;
            ST_PEEK1: state_nx = ST_STK0;
            ST_STK0:  state_nx = ST_STK1;
            ST_STK1:  state_nx = ST_STK2;
            ST_STK2:  state_nx = ST_VLO;
            ST_VLO:   state_nx = ST_VHI;
            ST_VHI:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        flg_new        = flg_w;
        flg_new[FLG_I] = 1'b1;
        if (CMOS_VARIANT)
            flg_new[FLG_D] = 1'b0;
    end

    // working registers and results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q    <= EK_NONE;
            pc_w      <= '0;
            sp_w      <= '0;
            flg_w     <= '0;
            vec_lo    <= '0;
            done      <= 1'b0;
            pc_out    <= '0;
            sp_out    <= '0;
            flags_out <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (kind_sel != EK_NONE) begin
                            kind_q <= kind_sel;
                            pc_w   <= pc_in;
                            sp_w   <= sp_in;
                            flg_w  <= flags_in;
                        end else begin
                            done      <= 1'b1;
                            pc_out    <= pc_in;
                            sp_out    <= sp_in;
                            flags_out <= flags_in;
                        end
                    end
                end
                ST_STK0, ST_STK1, ST_STK2: sp_w <= sp_w - 1'b1;
                ST_VLO: vec_lo <= rdata;
                ST_VHI: begin
                    pc_out    <= {rdata, vec_lo};
                    sp_out    <= sp_w;
                    flags_out <= flg_new;
                    done      <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R3: stack pointer steps down once per stack cycle
    a_r3_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STK0 || state == ST_STK1 || state == ST_STK2)
        |=> sp_w == $past(sp_w) - 8'd1);

    // R9: the cycle after the vector high byte is the done cycle
    a_r9_done_after_vhi: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_VHI |=> done && state == ST_IDLE);

    // R10: results move only with done
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(pc_out) && $stable(sp_out) && $stable(flags_out));

    // R6: interrupt disable set after any entry
    a_r6_i_set: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state) == ST_VHI |-> flags_out[FLG_I]);

endmodule

// File: rtl/irq_entry_bus.sv
module irq_entry_bus
    import irq_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state,
    input  entry_kind_t       kind_q,
    input  logic [ADDR_W-1:0] pc_w,
    input  logic [SP_W-1:0]   sp_w,
    input  logic [DATA_W-1:0] flg_w,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we
);

    logic [DATA_W-1:0] push_status;
    logic [ADDR_W-1:0] stack_addr;
    logic [ADDR_W-1:0] vec_addr;
    logic              pushing;

    always_comb begin
        push_status        = flg_w;
        push_status[FLG_U] = 1'b1;
        push_status[FLG_B] = 1'b0;
    end

    assign stack_addr = STACK_PAGE | {{(ADDR_W-SP_W){1'b0}}, sp_w};
    assign vec_addr   = vector_base(kind_q);
    assign pushing    = (kind_q != EK_RESET);

    always_comb begin
        bus_addr  = pc_w;
        bus_wdata = '0;
        bus_we    = 1'b0;
        unique case (state)
            ST_IDLE, ST_PEEK0, ST_PEEK1: bus_addr = pc_w;
            ST_STK0: begin
                bus_addr  = stack_addr;
                bus_wdata = pc_w[ADDR_W-1:DATA_W];
                bus_we    = pushing;
            end
            ST_STK1: begin
                bus_addr  = stack_addr;
                bus_wdata = pc_w[DATA_W-1:0];
                bus_we    = pushing;
            end
            ST_STK2: begin
                bus_addr  = stack_addr;
                bus_wdata = push_status;
                bus_we    = pushing;
            end
            ST_VLO: bus_addr = vec_addr;
            ST_VHI: bus_addr = vec_addr | 16'h0001;
        endcase
    end

    // R2: high vector byte follows the low one at the next address
    a_r2_vec_order: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_VLO |=> bus_addr == $past(bus_addr) + 16'd1);

    // R5: a reset entry never writes
    a_r5_reset_silent: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_IDLE && kind_q == EK_RESET |-> !bus_we);

    // R11: no write while idle
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !bus_we);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter bit CMOS_VARIANT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              reset_req,
    input  logic              nmi_req,
    input  logic              irq_level,
    input  logic              delay_all,
    input  logic              delay_irq,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [SP_W-1:0]   sp_in,
    input  logic [DATA_W-1:0] flags_in,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              done,
    output logic [ADDR_W-1:0] pc_out,
    output logic [SP_W-1:0]   sp_out,
    output logic [DATA_W-1:0] flags_out
);

    seq_state_t        state;
    entry_kind_t       kind_sel;
    entry_kind_t       kind_q;
    logic [ADDR_W-1:0] pc_w;
    logic [SP_W-1:0]   sp_w;
    logic [DATA_W-1:0] flg_w;
    logic              idle;
    logic              boundary;

    assign boundary = start && idle;

    irq_entry_arb #(.CMOS_VARIANT(CMOS_VARIANT)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary   (boundary),
        .reset_req  (reset_req),
        .nmi_req    (nmi_req),
        .irq_level  (irq_level),
        .irq_masked (flags_in[FLG_I]),
        .delay_all  (delay_all),
        .delay_irq  (delay_irq),
        .kind_sel   (kind_sel)
    );

    irq_entry_fsm #(.CMOS_VARIANT(CMOS_VARIANT)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .kind_sel  (kind_sel),
        .rdata     (bus_rdata),
        .pc_in     (pc_in),
        .sp_in     (sp_in),
        .flags_in  (flags_in),
        .state     (state),
        .kind_q    (kind_q),
        .pc_w      (pc_w),
        .sp_w      (sp_w),
        .flg_w     (flg_w),
        .idle      (idle),
        .done      (done),
        .pc_out    (pc_out),
        .sp_out    (sp_out),
        .flags_out (flags_out)
    );

    irq_entry_bus u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .kind_q    (kind_q),
        .pc_w      (pc_w),
        .sp_w      (sp_w),
        .flg_w     (flg_w),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we)
    );

endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        reset_req = 1'b0;
    logic        nmi_req = 1'b0;
    logic        irq_level = 1'b0;
    logic        delay_all = 1'b0;
    logic        delay_irq = 1'b0;
    logic [15:0] pc_in = 16'h1234;
    logic [7:0]  sp_in = 8'hFD;
    logic [7:0]  flags_in = 8'h00;

    logic [15:0] b_addr  [2];
    logic [7:0]  b_wdata [2];
    logic        b_we    [2];
    logic [7:0]  b_rdata [2];
    logic        d_done  [2];
    logic [15:0] d_pc    [2];
    logic [7:0]  d_sp    [2];
    logic [7:0]  d_flg   [2];

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mem_rd(logic [15:0] a);
        case (a)
            16'hFFFA: return 8'h23;
            16'hFFFB: return 8'hC1;
            16'hFFFC: return 8'h00;
            16'hFFFD: return 8'hE0;
            16'hFFFE: return 8'h56;
            16'hFFFF: return 8'hD4;
            default:  return a[7:0] ^ a[15:8] ^ 8'hA5;
        endcase
    endfunction

    assign b_rdata[0] = mem_rd(b_addr[0]);
    assign b_rdata[1] = mem_rd(b_addr[1]);

    irq_entry_seq #(.CMOS_VARIANT(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .reset_req(reset_req),
        .nmi_req(nmi_req), .irq_level(irq_level), .delay_all(delay_all),
        .delay_irq(delay_irq), .pc_in(pc_in), .sp_in(sp_in), .flags_in(flags_in),
        .bus_addr(b_addr[0]), .bus_wdata(b_wdata[0]), .bus_we(b_we[0]),
        .bus_rdata(b_rdata[0]), .done(d_done[0]), .pc_out(d_pc[0]),
        .sp_out(d_sp[0]), .flags_out(d_flg[0])
    );

    irq_entry_seq #(.CMOS_VARIANT(1'b1)) u_dut_cmos (
        .clk(clk), .rst_n(rst_n), .start(start), .reset_req(reset_req),
        .nmi_req(nmi_req), .irq_level(irq_level), .delay_all(delay_all),
        .delay_irq(delay_irq), .pc_in(pc_in), .sp_in(sp_in), .flags_in(flags_in),
        .bus_addr(b_addr[1]), .bus_wdata(b_wdata[1]), .bus_we(b_we[1]),
        .bus_rdata(b_rdata[1]), .done(d_done[1]), .pc_out(d_pc[1]),
        .sp_out(d_sp[1]), .flags_out(d_flg[1])
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model (index 1 = CMOS) -------
    int ph[2], kd[2], rp[2], np[2], used[2];
    int mpc[2], msp[2], mflg[2], lo[2];
    int epc[2], esp[2], eflg[2], edone[2];

    function automatic int vec_of(int k);
        return (k == 2) ? 32'hFFFA : (k == 1) ? 32'hFFFC : 32'hFFFE;
    endfunction

    always @(posedge clk) begin
        for (int v = 0; v < 2; v++) begin
            int r, n, act, pp, k;
            if (!rst_n) begin
                ph[v] = 0; kd[v] = 0; rp[v] = 0; np[v] = 0; used[v] = 0;
                mpc[v] = 0; msp[v] = 0; mflg[v] = 0; lo[v] = 0;
                epc[v] = 0; esp[v] = 0; eflg[v] = 0; edone[v] = 0;
            end else begin
                edone[v] = 0;
                r = rp[v] | int'(reset_req);
                n = np[v] | int'(nmi_req);
                if (ph[v] == 0 && start) begin
                    k = 0; pp = 0;
                    if (r != 0) k = 1;
                    else begin
                        act = n | int'(irq_level);
                        if (v == 0 && used[v] == 0 && act != 0 &&
                            (delay_all || (delay_irq && n == 0))) pp = 1;
                        used[v] = pp;
                        if (pp == 0) begin
                            if (n != 0) k = 2;
                            else if (irq_level && !flags_in[2]) k = 3;
                        end
                    end
                    rp[v] = (r != 0 && k != 1) ? 1 : 0;
                    np[v] = (n != 0 && k != 2) ? 1 : 0;
                    if (k == 0) begin
                        edone[v] = 1; epc[v] = pc_in; esp[v] = sp_in; eflg[v] = flags_in;
                    end else begin
                        ph[v] = 1; kd[v] = k; mpc[v] = pc_in; msp[v] = sp_in; mflg[v] = flags_in;
                    end
                end else begin
                    rp[v] = r; np[v] = n;
                    if (ph[v] != 0) begin
                        if (ph[v] >= 3 && ph[v] <= 5) msp[v] = (msp[v] - 1) & 255;
                        if (ph[v] == 6) lo[v] = mem_rd(16'(vec_of(kd[v])));
                        if (ph[v] == 7) begin
                            epc[v] = (int'(mem_rd(16'(vec_of(kd[v]) + 1))) << 8) | lo[v];
                            esp[v] = msp[v];
                            eflg[v] = mflg[v] | 4;
                            if (v == 1) eflg[v] = eflg[v] & ~8;
                            edone[v] = 1;
                        end
                        ph[v] = (ph[v] == 7) ? 0 : ph[v] + 1;
                    end
                end
            end
        end
    end

    // ---------------- per-cycle comparison, away from the active edge ----
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            for (int v = 0; v < 2; v++) begin
                string tg;
                tg = (kd[v] == 1) ? "R5" : "R3";
                if (ph[v] == 0) begin
                    chk("R11", "idle we", int'(b_we[v]), 0);
                end else if (ph[v] <= 2) begin
                    chk(tg, "peek addr", int'(b_addr[v]), mpc[v]);
                    chk(tg, "peek we", int'(b_we[v]), 0);
                end else if (ph[v] <= 5) begin
                    chk(tg, "stack addr", int'(b_addr[v]), 32'h100 | msp[v]);
                    chk(tg, "stack we", int'(b_we[v]), (kd[v] == 1) ? 0 : 1);
                    if (kd[v] != 1) begin
                        if (ph[v] == 3) chk("R3", "push pch", int'(b_wdata[v]), (mpc[v] >> 8) & 255);
                        if (ph[v] == 4) chk("R3", "push pcl", int'(b_wdata[v]), mpc[v] & 255);
                        if (ph[v] == 5) chk("R4", "push status", int'(b_wdata[v]), (mflg[v] | 32'h20) & ~32'h10);
                    end
                end else begin
                    chk("R2", "vector addr", int'(b_addr[v]), vec_of(kd[v]) + ph[v] - 6);
                end
                chk("R9", "done", int'(d_done[v]), edone[v]);
                chk("R10", "pc_out", int'(d_pc[v]), epc[v]);
                chk("R10", "sp_out", int'(d_sp[v]), esp[v]);
                chk("R6", "flags_out", int'(d_flg[v]), eflg[v]);
            end
        end
    end

    // ---------------- stimulus ------------------------------------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        tick(1);
        start = 1'b0;
    endtask

    task automatic entry_and_wait();
        pulse_start();
        tick(9);
    endtask

    task automatic summary();
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // reset state
        chk("R11", "reset we", int'(b_we[0]), 0);
        chk("R9", "reset done", int'(d_done[0]), 0);
        chk("R10", "reset pc_out", int'(d_pc[0]), 0);

        // nothing pending: immediate done, outputs follow inputs
        start = 1'b1;
        tick(1);
        start = 1'b0;
        chk("R9", "noop done", int'(d_done[0]), 1);
        chk("R9", "noop pc", int'(d_pc[0]), 16'h1234);
        tick(3);

        // masked IRQ ignored
        flags_in = 8'h04; irq_level = 1'b1;
        entry_and_wait();
        chk("R1", "masked irq pc", int'(d_pc[0]), 16'h1234);

        // IRQ with decimal set: variants differ in D
        flags_in = 8'h08;
        entry_and_wait();
        chk("R2", "irq vector", int'(d_pc[0]), 16'hD456);
        chk("R3", "irq sp", int'(d_sp[0]), 8'hFA);
        chk("R6", "nmos flags", int'(d_flg[0]), 8'h0C);
        chk("R6", "cmos flags", int'(d_flg[1]), 8'h04);
        irq_level = 1'b0; flags_in = 8'h00;

        // NMI pulse latched while idle
        nmi_req = 1'b1; tick(1); nmi_req = 1'b0; tick(3);
        entry_and_wait();
        chk("R7", "latched nmi", int'(d_pc[0]), 16'hC123);

        // all three at once: reset, then NMI, then IRQ
        reset_req = 1'b1; nmi_req = 1'b1; tick(1);
        reset_req = 1'b0; nmi_req = 1'b0; irq_level = 1'b1;
        entry_and_wait();
        chk("R1", "reset first", int'(d_pc[0]), 16'hE000);
        chk("R5", "reset sp", int'(d_sp[0]), 8'hFA);
        entry_and_wait();
        chk("R1", "nmi second", int'(d_pc[0]), 16'hC123);
        entry_and_wait();
        chk("R1", "irq third", int'(d_pc[0]), 16'hD456);

        // NMOS postpone-any hint, once
        pc_in = 16'h2222;
        delay_all = 1'b1;
        entry_and_wait();
        chk("R8", "nmos postponed", int'(d_pc[0]), 16'h2222);
        chk("R8", "cmos not postponed", int'(d_pc[1]), 16'hD456);
        entry_and_wait();
        chk("R8", "nmos served after one", int'(d_pc[0]), 16'hD456);
        delay_all = 1'b0;

        // IRQ-only hint does not hold back an NMI
        delay_irq = 1'b1;
        nmi_req = 1'b1; tick(1); nmi_req = 1'b0;
        entry_and_wait();
        chk("R8", "nmi beats irq hint", int'(d_pc[0]), 16'hC123);
        entry_and_wait();
        chk("R8", "irq hint postpones", int'(d_pc[0]), 16'h2222);
        chk("R8", "cmos ignores hint", int'(d_pc[1]), 16'hD456);
        delay_irq = 1'b0; irq_level = 1'b0;
        entry_and_wait();

        // reset not postponed by hints
        delay_all = 1'b1; reset_req = 1'b1; tick(1); reset_req = 1'b0;
        entry_and_wait();
        chk("R8", "reset ignores hint", int'(d_pc[0]), 16'hE000);
        delay_all = 1'b0;

        // stack wrap and start during an entry
        sp_in = 8'h01; irq_level = 1'b1;
        pulse_start();
        tick(2);
        pulse_start();
        tick(6);
        chk("R3", "sp wrap", int'(d_sp[0]), 8'hFE);
        chk("R10", "busy start ignored", int'(d_pc[0]), 16'hD456);
        irq_level = 1'b0;
        tick(4);

        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
        end
    end

endmodule